// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block looks for the PLL setting that best reproduces a requested dot clock. It takes a target frequency in kHz and a channel select on a single-cycle start pulse. It then walks every divider allowed for that channel in ascending order. For each divider it forms candidate PLL multipliers by integer division against a 3 MHz reference step. It keeps the candidate whose achieved rate lies closest to the target without going above it.

Two families of candidates are tried. The plain family uses the 3 MHz step for every divider. The doubled family uses a 6 MHz step and is tried only when the divider is odd. All divisions go through one shared restoring divider that produces one quotient bit per cycle, so a full search takes several thousand cycles.

When the search ends, the block raises a one-cycle done pulse. At that point the chosen multiplier, the divider, the doubler flag, the resulting PLL frequency (multiplier times 3000 kHz) and a found flag are valid. They stay valid until the next accepted start. Programming the PLL and gating clocks are left to the surrounding logic.

Top module: `pclk_search`

## Requirements
- R1: After reset, busy, done and found are low, and the multiplier, divider, doubler flag and PLL frequency outputs are all zero.
- R2: With chan_sel = 0, dividers 6 through 127 are searched. With chan_sel = 1, dividers 1 through 15 are searched. Both are searched in ascending order, and no divider outside the channel's range is ever chosen.
- R3: For divider m and target T, the plain candidate is n = floor(m*T/3000). It is only considered when 9 <= n <= 127. Its achieved rate is floor(3000*n/m) kHz and its error is T minus that rate.
- R4: The doubled candidate is tried only for odd m. It uses n = floor(m*T/6000) with the same 9..127 window, and its achieved rate is floor(6000*n/m) kHz. A chosen doubled candidate raises dbl_sel.
- R5: A candidate becomes the new best only if its error is strictly below the best error so far, which starts at 0x0FFFFFFF. An equal error therefore leaves the smaller divider in place, and at the same divider the plain candidate keeps the place over the doubled one.
- R6: pll_khz equals best_n * 3000 for the chosen candidate, whatever the value of dbl_sel.
- R7: If no divider yields a candidate inside the window, done still pulses, with found low and best_n, best_m, dbl_sel and pll_khz all zero.
- R8: A start raised while a search is running has no effect: the search and its result belong to the request that was accepted.
- R9: done is high for exactly one cycle per search, and busy is low while done is high. The results stay unchanged after done until the next start is accepted.
- R10: The achieved rate of the chosen candidate never exceeds the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; accepted only when idle |
| chan_sel | input | 1 | Channel: 0 wide divider range, 1 narrow range |
| target_khz | input | 20 | Requested dot clock in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | A candidate inside the window was chosen |
| best_n | output | 7 | Chosen PLL multiplier |
| best_m | output | 7 | Chosen divider |
| dbl_sel | output | 1 | Chosen candidate came from the doubled family |
| pll_khz | output | 19 | PLL frequency, best_n * 3000 kHz |

## Verification
The properties assume that target_khz and chan_sel matter only in the cycle where start is accepted. They also assume that start is ignored unless the block is idle, so they never relate results to inputs seen during a search. The bench holds start for a single cycle, keeps targets inside the 20-bit range, and pulses a second start in the middle of a search only to show that it is ignored. Expected winners were worked out by hand from the search rule for targets chosen to hit exact matches, ties across dividers, ties between families, doubled-only wins, and both ways of finding nothing (targets too low and too high).

// File: rtl/pclk_pkg.sv
package pclk_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_QLAUNCH,
    S_QWAIT,
    S_RWAIT,
    S_STEP,
    S_DONE
  } srch_state_t;

  localparam logic [31:0] ERR_START = 32'h0FFF_FFFF;

endpackage

// File: rtl/pclk_divider.sv
module pclk_divider #(
  parameter int W = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         fin,
  output logic [W-1:0] quot
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  den_q, den_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          fin_q, fin_d;
  logic          dp_en;
  logic [W+1:0]  shifted;
  logic [W+1:0]  trial;

  assign dp_en = go | run_q;

  always_comb begin
    rem_d   = rem_q;
    quo_d   = quo_q;
    den_d   = den_q;
    cnt_d   = cnt_q;
    run_d   = run_q;
    fin_d   = 1'b0;
    shifted = {1'b0, rem_q, quo_q[W-1]};
    trial   = shifted - {2'b00, den_q};
    if (go && !run_q) begin
      rem_d = '0;
      quo_d = num;
      den_d = den;
      cnt_d = CW'(W);
      run_d = 1'b1;
    end else if (run_q) begin
      if (!trial[W+1]) begin
        rem_d = trial[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = shifted[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      run_q <= run_d;
      fin_q <= fin_d;
      if (dp_en) begin
        rem_q <= rem_d;
        quo_q <= quo_d;
        den_q <= den_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign fin  = fin_q;
  assign quot = quo_q;

endmodule

// File: rtl/pclk_best.sv
module pclk_best #(
  parameter int N_W      = 7,
  parameter int M_W      = 7,
  parameter int EW       = 28,
  parameter int PW       = 19,
  parameter int BASE_KHZ = 3000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           upd,
  input  logic [EW-1:0]  cand_err,
  input  logic [N_W-1:0] cand_n,
  input  logic [M_W-1:0] cand_m,
  input  logic           cand_dbl,
  output logic [N_W-1:0] best_n,
  output logic [M_W-1:0] best_m,
  output logic           best_dbl,
  output logic [PW-1:0]  best_pll,
  output logic           found
);

  localparam logic [EW-1:0] ERR_INIT = EW'(pclk_pkg::ERR_START);

  logic [EW-1:0]  err_q, err_d;
  logic [N_W-1:0] n_q, n_d;
  logic [M_W-1:0] m_q, m_d;
  logic           dbl_q, dbl_d;
  logic [PW-1:0]  pll_q, pll_d;
  logic           fnd_q, fnd_d;
  logic           take;
  logic           reg_en;

  assign take   = upd && (cand_err < err_q);
  assign reg_en = clr | take;

  always_comb begin
    err_d = err_q;
    n_d   = n_q;
    m_d   = m_q;
    dbl_d = dbl_q;
    pll_d = pll_q;
    fnd_d = fnd_q;
    if (clr) begin
      err_d = ERR_INIT;
      n_d   = '0;
      m_d   = '0;
      dbl_d = 1'b0;
      pll_d = '0;
      fnd_d = 1'b0;
    end else if (take) begin
      err_d = cand_err;
      n_d   = cand_n;
      m_d   = cand_m;
      dbl_d = cand_dbl;
      pll_d = PW'(cand_n) * PW'(BASE_KHZ);
      fnd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= ERR_INIT;
      n_q   <= '0;
      m_q   <= '0;
      dbl_q <= 1'b0;
      pll_q <= '0;
      fnd_q <= 1'b0;
    end else if (reg_en) begin
      err_q <= err_d;
      n_q   <= n_d;
      m_q   <= m_d;
      dbl_q <= dbl_d;
      pll_q <= pll_d;
      fnd_q <= fnd_d;
    end
  end

  assign best_n   = n_q;
  assign best_m   = m_q;
  assign best_dbl = dbl_q;
  assign best_pll = pll_q;
  assign found    = fnd_q;

endmodule

// File: rtl/pclk_search.sv
module pclk_search #(
  parameter int DOT_W    = 20,
  parameter int M_W      = 7,
  parameter int N_W      = 7,
  parameter int N_LO     = 9,
  parameter int N_HI     = 127,
  parameter int BASE_KHZ = 3000,
  parameter int CH0_M_LO = 6,
  parameter int CH0_M_HI = 127,
  parameter int CH1_M_LO = 1,
  parameter int CH1_M_HI = 15,
  parameter int PW       = $clog2(N_HI * BASE_KHZ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             chan_sel,
  input  logic [DOT_W-1:0] target_khz,
  output logic             busy,
  output logic             done,
  output logic             found,
  output logic [N_W-1:0]   best_n,
  output logic [M_W-1:0]   best_m,
  output logic             dbl_sel,
  output logic [PW-1:0]    pll_khz
);

  import pclk_pkg::*;

  localparam int NUM_W = DOT_W + M_W;
  localparam int EW    = (NUM_W + 1 > 28) ? NUM_W + 1 : 28;

  srch_state_t      state_q, state_d;
  logic [DOT_W-1:0] tgt_q, tgt_d;
  logic             chan_q, chan_d;
  logic [M_W-1:0]   m_q, m_d;
  logic             fam_q, fam_d;
  logic [N_W-1:0]   cn_q, cn_d;

  logic             div_go;
  logic [NUM_W-1:0] div_num;
  logic [NUM_W-1:0] div_den;
  logic             div_fin;
  logic [NUM_W-1:0] div_quot;

  logic             trk_clr;
  logic             trk_upd;
  logic [EW-1:0]    cand_err;

  logic [NUM_W-1:0] step_khz;
  logic [NUM_W-1:0] prod_mt;
  logic [NUM_W-1:0] prod_nf;
  logic [M_W-1:0]   m_first;
  logic [M_W-1:0]   m_last;
  logic             q_in_win;
  logic             ctl_en;

  assign step_khz = fam_q ? NUM_W'(2 * BASE_KHZ) : NUM_W'(BASE_KHZ);
  assign prod_mt  = NUM_W'(m_q) * NUM_W'(tgt_q);
  assign prod_nf  = NUM_W'(div_quot[N_W-1:0]) * step_khz;
  assign m_first  = chan_sel ? M_W'(CH1_M_LO) : M_W'(CH0_M_LO);
  assign m_last   = chan_q ? M_W'(CH1_M_HI) : M_W'(CH0_M_HI);
  assign q_in_win = (div_quot >= NUM_W'(N_LO)) && (div_quot <= NUM_W'(N_HI));
  assign cand_err = EW'(tgt_q) - EW'(div_quot);

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    chan_d  = chan_q;
    m_d     = m_q;
    fam_d   = fam_q;
    cn_d    = cn_q;
    div_go  = 1'b0;
    div_num = prod_mt;
    div_den = step_khz;
    trk_clr = 1'b0;
    trk_upd = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          tgt_d   = target_khz;
          chan_d  = chan_sel;
          m_d     = m_first;
          fam_d   = 1'b0;
          trk_clr = 1'b1;
          state_d = S_QLAUNCH;
        end
      end
      S_QLAUNCH: begin
        div_go  = 1'b1;
        state_d = S_QWAIT;
      end
      S_QWAIT: begin
        if (div_fin) begin
          if (q_in_win) begin
            cn_d    = div_quot[N_W-1:0];
            div_go  = 1'b1;
            div_num = prod_nf;
            div_den = NUM_W'(m_q);
            state_d = S_RWAIT;
          end else begin
            state_d = S_STEP;
          end
        end
      end
      S_RWAIT: begin
        if (div_fin) begin
          trk_upd = 1'b1;
          state_d = S_STEP;
        end
      end
      S_STEP: begin
        if (!fam_q && m_q[0]) begin
          fam_d   = 1'b1;
          state_d = S_QLAUNCH;
        end else if (m_q == m_last) begin
          state_d = S_DONE;
        end else begin
          m_d     = m_q + 1'b1;
          fam_d   = 1'b0;
          state_d = S_QLAUNCH;
        end
      end
      S_DONE: begin
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign ctl_en = (state_q != S_IDLE) || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tgt_q   <= '0;
      chan_q  <= 1'b0;
      m_q     <= '0;
      fam_q   <= 1'b0;
      cn_q    <= '0;
    end else if (ctl_en) begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      chan_q  <= chan_d;
      m_q     <= m_d;
      fam_q   <= fam_d;
      cn_q    <= cn_d;
    end
  end

  pclk_divider #(
    .W (NUM_W)
  ) i_div (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (div_go),
    .num  (div_num),
    .den  (div_den),
    .fin  (div_fin),
    .quot (div_quot)
  );

  pclk_best #(
    .N_W     (N_W),
    .M_W     (M_W),
    .EW      (EW),
    .PW      (PW),
    .BASE_KHZ(BASE_KHZ)
  ) i_best (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (trk_clr),
    .upd     (trk_upd),
    .cand_err(cand_err),
    .cand_n  (cn_q),
    .cand_m  (m_q),
    .cand_dbl(fam_q),
    .best_n  (best_n),
    .best_m  (best_m),
    .best_dbl(dbl_sel),
    .best_pll(pll_khz),
    .found   (found)
  );

  assign busy = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done = (state_q == S_DONE);

endmodule

// File: rtl/pclk_search_chk.sv
module pclk_search_chk #(
  parameter int M_W      = 7,
  parameter int N_W      = 7,
  parameter int N_LO     = 9,
  parameter int N_HI     = 127,
  parameter int BASE_KHZ = 3000,
  parameter int CH1_M_LO = 1,
  parameter int CH0_M_HI = 127,
  parameter int PW       = 19
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           found,
  input logic [N_W-1:0] best_n,
  input logic [M_W-1:0] best_m,
  input logic           dbl_sel,
  input logic [PW-1:0]  pll_khz
);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && !start) |=>
      ($stable(best_n) && $stable(best_m) && $stable(dbl_sel) && $stable(found)));

  a_r8_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && start) |=> busy);

  a_r7_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (best_n == '0 && best_m == '0 && !dbl_sel && pll_khz == '0));

  a_r3_n_window: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (best_n >= N_W'(N_LO) && best_n <= N_W'(N_HI)));

  a_r2_m_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (best_m >= M_W'(CH1_M_LO) && best_m <= M_W'(CH0_M_HI)));

  a_r4_dbl_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dbl_sel) |-> best_m[0]);

  a_r6_pll_value: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pll_khz == PW'(best_n) * PW'(BASE_KHZ)));

endmodule

bind pclk_search pclk_search_chk #(
  .M_W     (M_W),
  .N_W     (N_W),
  .N_LO    (N_LO),
  .N_HI    (N_HI),
  .BASE_KHZ(BASE_KHZ),
  .CH1_M_LO(CH1_M_LO),
  .CH0_M_HI(CH0_M_HI),
  .PW      (PW)
) i_chk (.*);

// File: tb/test_pclk_search.sv
`timescale 1ns/1ps
module test_pclk_search;

  localparam int RUN_LIMIT = 30000;
  localparam int NV = 10;
  localparam bit VCH [NV] = '{1, 1, 1, 1, 0, 0, 0, 1, 1, 0};
  localparam int VT  [NV] = '{3000, 25000, 500000, 60000, 60000, 27000, 100000, 1000, 800000, 100};
  localparam bit VF  [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 0, 0};
  localparam int VN  [NV] = '{9, 25, 83, 20, 120, 54, 116, 0, 0, 0};
  localparam int VM  [NV] = '{9, 3, 1, 1, 6, 6, 7, 0, 0, 0};
  localparam bit VD  [NV] = '{0, 0, 1, 0, 0, 0, 1, 0, 0, 0};

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        chan_sel;
  logic [19:0] target_khz;
  logic        busy;
  logic        done;
  logic        found;
  logic [6:0]  best_n;
  logic [6:0]  best_m;
  logic        dbl_sel;
  logic [18:0] pll_khz;

  int checks;
  int errors;

  pclk_search i_pclk_search (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .chan_sel  (chan_sel),
    .target_khz(target_khz),
    .busy      (busy),
    .done      (done),
    .found     (found),
    .best_n    (best_n),
    .best_m    (best_m),
    .dbl_sel   (dbl_sel),
    .pll_khz   (pll_khz)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic pulse_start(input bit ch, input int t);
    @(negedge clk);
    start      = 1'b1;
    chan_sel   = ch;
    target_khz = 20'(t);
    @(negedge clk);
    start      = 1'b0;
  endtask

  task automatic wait_done();
    int w = 0;
    while (!done && w < RUN_LIMIT) begin
      @(negedge clk);
      w++;
    end
    if (!done) begin
      check("R9", "watchdog expired waiting for done", 0, 1);
      finish_run();
    end
  endtask

  initial begin
    checks     = 0;
    errors     = 0;
    rst_n      = 1'b0;
    start      = 1'b0;
    chan_sel   = 1'b0;
    target_khz = '0;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "found", found, 0);
    check("R1", "best_n", best_n, 0);
    check("R1", "best_m", best_m, 0);
    check("R1", "dbl_sel", dbl_sel, 0);
    check("R1", "pll_khz", pll_khz, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R4/R5/R6/R7/R10: vector table
    for (int v = 0; v < NV; v++) begin
      pulse_start(VCH[v], VT[v]);
      check("R9", $sformatf("busy during vector %0d", v), busy, 1);
      wait_done();
      check("R3/R5", $sformatf("found vector %0d", v), found, VF[v]);
      check("R2/R3", $sformatf("best_n vector %0d", v), best_n, VN[v]);
      check("R2/R5", $sformatf("best_m vector %0d", v), best_m, VM[v]);
      check("R4", $sformatf("dbl_sel vector %0d", v), dbl_sel, VD[v]);
      check("R6", $sformatf("pll_khz vector %0d", v), pll_khz, VN[v] * 3000);
      if (!VF[v]) check("R7", $sformatf("no candidate vector %0d", v), {found, best_n, best_m, dbl_sel}, 0);
      if (found && best_m != 0) begin
        longint rate = ((dbl_sel ? 6000 : 3000) * longint'(best_n)) / best_m;
        check("R10", $sformatf("rate not above target vector %0d", v), (rate <= VT[v]) ? 1 : 0, 1);
      end
      check("R9", $sformatf("busy low with done vector %0d", v), busy, 0);
      @(negedge clk);
      check("R9", $sformatf("done single cycle vector %0d", v), done, 0);
      repeat (3) @(negedge clk);
      check("R9", $sformatf("result held vector %0d", v), {best_n, best_m, dbl_sel}, {7'(VN[v]), 7'(VM[v]), VD[v]});
    end

    // R8: a start raised while busy is ignored
    pulse_start(1'b1, 3000);
    repeat (8) @(negedge clk);
    check("R8", "busy before second start", busy, 1);
    start      = 1'b1;
    chan_sel   = 1'b0;
    target_khz = 20'(500000);
    @(negedge clk);
    start      = 1'b0;
    wait_done();
    check("R8", "best_n keeps first request", best_n, 9);
    check("R8", "best_m keeps first request", best_m, 9);
    check("R8", "dbl_sel keeps first request", dbl_sel, 0);
    @(negedge clk);
    check("R8", "no second search", busy, 0);

    // R5: a repeat of the tie case after a doubled winner clears the old result
    pulse_start(1'b1, 500000);
    wait_done();
    check("R4", "doubled winner again", dbl_sel, 1);
    pulse_start(1'b1, 60000);
    wait_done();
    check("R5", "plain beats doubled at equal error", dbl_sel, 0);
    check("R5", "tie divider", best_m, 1);

    finish_run();
  end

  initial begin
    #(4 * 190000);
    check("R9", "global watchdog", 0, 1);
    finish_run();
  end

endmodule